// File: doc/BRIEF.md
# Helper Thread Spawn Controller

This block supervises the cores of a four-core chip multiprocessor that runs a totally ordered set of speculative threads. Each core holds an ordered thread, a helper thread, or nothing. When the most speculative ordered thread takes a second-level cache miss whose value can be predicted with confidence, and a core is idle, the controller clones that thread onto the idle core as a helper. The helper runs ahead to warm caches. Its results are never committed.

The controller tracks the helper's parent and its core. It kills the helper as soon as any of these happens: its parent loses the most speculative position, the parent or the helper finishes, or the helper faults. A kill tells the helper core to throw away its state. While a helper is live, the squash filter keeps that core out of squash traffic in both directions.

Top module: `helper_spawn_ctrl`

## Requirements
- R1: After reset no helper is recorded (`hlp_valid_o` low) and neither `spawn_o` nor `kill_o` is asserted while inputs are idle.
- R2: The lead core is the busy non-helper core with the largest rank; on equal ranks the lower core index wins. `spawn_o` rises in the cycle in which the lead core has both `miss_pred` and `conf_ok` set. Requests from any other core are ignored. `spawn_parent_o` names the lead core.
- R3: When no core is free, a request produces no spawn and is not remembered. A core that frees later with no request present causes no spawn.
- R4: A free core is one that is neither busy nor holding the helper. `spawn_core_o` is the lowest-numbered free core.
- R5: In the cycle after a spawn, `hlp_valid_o` is 1 and `hlp_parent_o`/`hlp_core_o` hold the spawn's parent and core.
- R6: `kill_o` is asserted in the same cycle that the parent stops being the lead core, either because a higher-ranked thread appears or because the parent is no longer busy.
- R7: `kill_o` is asserted in the same cycle that `core_done` is set on the parent core or on the helper core.
- R8: `kill_o` is asserted in the same cycle that `core_exc` is set on the helper core.
- R9: Kill causes that coincide give one single-cycle `kill_o` pulse. During that pulse `kill_core_o` names the helper core and `discard_o` is one-hot on it.
- R10: In the cycle after a kill, the slot is empty and the old helper core counts as free, so it can be chosen by a new spawn.
- R11: While a helper is live, its bit is cleared in `sq_deliver_o` (incoming squashes) and in `sq_emit_o` (squashes it raises). All other bits pass through unchanged.
- R12: At most one helper is live. No spawn occurs while `hlp_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_busy | input | N | Core holds an ordered speculative thread |
| core_rank | input | N*RW | Order rank per core, core i at bits [i*RW +: RW]; larger is more speculative |
| core_done | input | N | Thread on the core has finished |
| core_exc | input | N | Thread on the core raised an exception |
| miss_pred | input | N | Cache miss with a predictable value on the core |
| conf_ok | input | N | Address-based confidence for that miss |
| sq_in | input | N | Squash requests aimed at each core |
| sq_raise | input | N | Squash requests raised by each core |
| spawn_o | output | 1 | Clone the lead thread this cycle |
| spawn_core_o | output | IDW | Core chosen for the new helper |
| spawn_parent_o | output | IDW | Core of the cloned parent |
| kill_o | output | 1 | Kill the helper this cycle |
| kill_core_o | output | IDW | Core of the killed helper |
| discard_o | output | N | One-hot: drop this core's state without commit |
| sq_deliver_o | output | N | Incoming squashes after filtering |
| sq_emit_o | output | N | Raised squashes after filtering |
| hlp_valid_o | output | 1 | A helper is live |
| hlp_parent_o | output | IDW | Parent core of the live helper |
| hlp_core_o | output | IDW | Core of the live helper |

## Verification
Several properties are checked by assertions on every cycle:
- the slot is filled correctly after each spawn,
- no spawn happens while a helper lives,
- each kill is one cycle long and is followed by an empty slot,
- a faulting helper is always killed,
- squash isolation holds on the helper core.

Other behaviour can only be shown by the bench scenarios, because it depends on chosen stimulus:
- which core wins the lead when ranks tie,
- that requests from non-lead cores and requests made with no free core are dropped,
- that the lowest free core is picked,
- that a freed helper core is reused at once.

// File: rtl/hts_pkg.sv
// Package: shared types for the helper spawn controller.
// Assumes: at most four kill causes, evaluated each cycle.
package hts_pkg;

    // Reasons for ending a helper; any set bit kills it.
    typedef struct packed {
        logic lost_lead;
        logic parent_done;
        logic self_done;
        logic self_exc;
    } kill_cause_t;

    // Reduce a cause vector to one kill decision.
    function automatic logic any_cause(input kill_cause_t c);
        return c.lost_lead | c.parent_done | c.self_done | c.self_exc;
    endfunction

endpackage

// File: rtl/hts_lead_finder.sv
// Finds the most speculative ordered thread: the eligible core with the
// largest rank, lowest index winning ties.
// Assumes: eligible excludes the helper core; ranks are unsigned.
module hts_lead_finder #(
    parameter int N   = 4,
    parameter int RW  = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    eligible,
    input  logic [N*RW-1:0] rank,
    output logic            lead_vld,
    output logic [IDW-1:0]  lead_idx
);

    logic [RW-1:0] best_rank;

    // Linear scan keeping the first strictly larger rank.
    always_comb begin
        lead_vld  = 1'b0;
        lead_idx  = '0;
        best_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && (!lead_vld || rank[i*RW +: RW] > best_rank)) begin
                lead_vld  = 1'b1;
                lead_idx  = IDW'(i);
                best_rank = rank[i*RW +: RW];
            end
        end
    end

endmodule

// File: rtl/hts_free_pick.sv
// Picks the lowest-numbered free core.
// Assumes: free already excludes busy and helper-occupied cores.
module hts_free_pick #(
    parameter int N   = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   free_mask,
    output logic           free_any,
    output logic [IDW-1:0] free_idx
);

    // Priority scan from the top so the lowest set bit is kept last.
    always_comb begin
        free_any = |free_mask;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_mask[i]) free_idx = IDW'(i);
        end
    end

endmodule

// File: rtl/hts_helper_slot.sv
// Holds the single helper record (valid, parent, core), decides kills
// and produces the one-hot helper mask and discard strobe.
// Assumes: spawn is never asserted while the slot is valid.
module hts_helper_slot
    import hts_pkg::*;
#(
    parameter int N   = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spawn,
    input  logic [IDW-1:0] new_core,
    input  logic [IDW-1:0] new_parent,
    input  logic           lead_vld,
    input  logic [IDW-1:0] lead_idx,
    input  logic [N-1:0]   core_done,
    input  logic [N-1:0]   core_exc,
    output logic           valid,
    output logic [IDW-1:0] parent,
    output logic [IDW-1:0] core,
    output logic           kill,
    output logic [N-1:0]   helper_mask,
    output logic [N-1:0]   discard
);

    kill_cause_t cause;

    // Gather every reason to end the live helper.
    always_comb begin
        cause.lost_lead   = !lead_vld || (lead_idx != parent);
        cause.parent_done = core_done[parent];
        cause.self_done   = core_done[core];
        cause.self_exc    = core_exc[core];
        kill              = valid && any_cause(cause);
    end

    // Per-core mask and discard strobe.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            helper_mask[i] = valid && (core == IDW'(i));
            discard[i]     = kill && (core == IDW'(i));
        end
    end

    // Slot register: a kill empties it, a spawn fills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            parent <= '0;
            core   <= '0;
        end else if (kill) begin
            valid  <= 1'b0;
        end else if (spawn) begin
            valid  <= 1'b1;
            parent <= new_parent;
            core   <= new_core;
        end
    end

endmodule

// File: rtl/hts_squash_gate.sv
// Blocks squash traffic into and out of the helper core.
// Assumes: helper_mask is one-hot or zero.
module hts_squash_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] helper_mask,
    input  logic [N-1:0] sq_in,
    input  logic [N-1:0] sq_raise,
    output logic [N-1:0] sq_deliver,
    output logic [N-1:0] sq_emit
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        // One gate pair per core.
        always_comb begin
            sq_deliver[g] = sq_in[g]    && !helper_mask[g];
            sq_emit[g]    = sq_raise[g] && !helper_mask[g];
        end
    end

endmodule

// File: rtl/helper_spawn_ctrl.sv
// Top of the helper spawn controller: clones the lead ordered thread onto
// the lowest free core when it reports a confident predictable miss, kills
// the helper on lead loss, completion or exception, and isolates it from
// squashes.
// Assumes: the environment keeps core_busy low on the helper core.
module helper_spawn_ctrl #(
    parameter int N   = 4,
    parameter int RW  = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    core_busy,
    input  logic [N*RW-1:0] core_rank,
    input  logic [N-1:0]    core_done,
    input  logic [N-1:0]    core_exc,
    input  logic [N-1:0]    miss_pred,
    input  logic [N-1:0]    conf_ok,
    input  logic [N-1:0]    sq_in,
    input  logic [N-1:0]    sq_raise,
    output logic            spawn_o,
    output logic [IDW-1:0]  spawn_core_o,
    output logic [IDW-1:0]  spawn_parent_o,
    output logic            kill_o,
    output logic [IDW-1:0]  kill_core_o,
    output logic [N-1:0]    discard_o,
    output logic [N-1:0]    sq_deliver_o,
    output logic [N-1:0]    sq_emit_o,
    output logic            hlp_valid_o,
    output logic [IDW-1:0]  hlp_parent_o,
    output logic [IDW-1:0]  hlp_core_o
);

    logic [N-1:0]   hmask;
    logic [N-1:0]   ordered;
    logic [N-1:0]   free_mask;
    logic           lead_vld;
    logic [IDW-1:0] lead_idx;
    logic           free_any;
    logic [IDW-1:0] free_idx;

    // Ordered candidates and free cores.
    always_comb begin
        ordered   = core_busy & ~hmask;
        free_mask = ~core_busy & ~hmask;
    end

    hts_lead_finder #(.N(N), .RW(RW)) u_lead (
        .eligible (ordered),
        .rank     (core_rank),
        .lead_vld (lead_vld),
        .lead_idx (lead_idx)
    );

    hts_free_pick #(.N(N)) u_free (
        .free_mask (free_mask),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    // Spawn eligibility: lead core, confident predictable miss, a free core, empty slot.
    always_comb begin
        spawn_o        = lead_vld && miss_pred[lead_idx] && conf_ok[lead_idx]
                         && free_any && !hlp_valid_o;
        spawn_core_o   = free_idx;
        spawn_parent_o = lead_idx;
    end

    hts_helper_slot #(.N(N)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .spawn       (spawn_o),
        .new_core    (free_idx),
        .new_parent  (lead_idx),
        .lead_vld    (lead_vld),
        .lead_idx    (lead_idx),
        .core_done   (core_done),
        .core_exc    (core_exc),
        .valid       (hlp_valid_o),
        .parent      (hlp_parent_o),
        .core        (hlp_core_o),
        .kill        (kill_o),
        .helper_mask (hmask),
        .discard     (discard_o)
    );

    // The killed core is always the recorded helper core.
    always_comb kill_core_o = hlp_core_o;

    hts_squash_gate #(.N(N)) u_sq (
        .helper_mask (hmask),
        .sq_in       (sq_in),
        .sq_raise    (sq_raise),
        .sq_deliver  (sq_deliver_o),
        .sq_emit     (sq_emit_o)
    );

endmodule

// File: rtl/helper_spawn_ctrl_chk.sv
// Checker for helper_spawn_ctrl, attached by bind.
module helper_spawn_ctrl_chk #(
    parameter int N   = 4,
    parameter int RW  = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   core_busy,
    input logic [N-1:0]   core_exc,
    input logic           spawn_o,
    input logic [IDW-1:0] spawn_core_o,
    input logic [IDW-1:0] spawn_parent_o,
    input logic           kill_o,
    input logic [N-1:0]   discard_o,
    input logic [N-1:0]   sq_deliver_o,
    input logic [N-1:0]   sq_emit_o,
    input logic           hlp_valid_o,
    input logic [IDW-1:0] hlp_parent_o,
    input logic [IDW-1:0] hlp_core_o
);

    // R5
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_o |=> hlp_valid_o && hlp_core_o == $past(spawn_core_o)
                    && hlp_parent_o == $past(spawn_parent_o));

    // R12
    single_helper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_o |-> !hlp_valid_o);

    // R4
    spawn_free_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_o |-> !core_busy[spawn_core_o]);

    // R8
    exc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hlp_valid_o && core_exc[hlp_core_o]) |-> kill_o);

    // R9
    kill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> !kill_o);

    // R9
    discard_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> $countones(discard_o) == 1 && discard_o[hlp_core_o]);

    // R10
    slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> !hlp_valid_o);

    // R11
    squash_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlp_valid_o |-> !sq_deliver_o[hlp_core_o] && !sq_emit_o[hlp_core_o]);

endmodule

bind helper_spawn_ctrl helper_spawn_ctrl_chk #(.N(N), .RW(RW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_busy      (core_busy),
    .core_exc       (core_exc),
    .spawn_o        (spawn_o),
    .spawn_core_o   (spawn_core_o),
    .spawn_parent_o (spawn_parent_o),
    .kill_o         (kill_o),
    .discard_o      (discard_o),
    .sq_deliver_o   (sq_deliver_o),
    .sq_emit_o      (sq_emit_o),
    .hlp_valid_o    (hlp_valid_o),
    .hlp_parent_o   (hlp_parent_o),
    .hlp_core_o     (hlp_core_o)
);

// File: tb/helper_spawn_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module helper_spawn_ctrl_bench;

    localparam int N   = 4;
    localparam int RW  = 4;
    localparam int IDW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    core_busy, core_done, core_exc, miss_pred, conf_ok, sq_in, sq_raise;
    logic [N*RW-1:0] core_rank;
    logic            spawn_o, kill_o, hlp_valid_o;
    logic [IDW-1:0]  spawn_core_o, spawn_parent_o, kill_core_o, hlp_parent_o, hlp_core_o;
    logic [N-1:0]    discard_o, sq_deliver_o, sq_emit_o;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    helper_spawn_ctrl #(.N(N), .RW(RW)) u_helper_spawn_ctrl (.*);

    // Compare one value and log a failure line.
    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Set the four ranks.
    task automatic ranks(input int r0, input int r1, input int r2, input int r3);
        core_rank = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
    endtask

    // Clear pulse-type inputs.
    task automatic quiet();
        core_done = '0; core_exc = '0; miss_pred = '0; conf_ok = '0;
        sq_in = '0; sq_raise = '0;
    endtask

    // Advance one cycle; inputs change at the falling edge, then settle.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Spawn from the current lead with a confident request, one cycle.
    task automatic do_spawn(input int parent);
        miss_pred = 4'b1 << parent; conf_ok = 4'b1 << parent;
        #1;
        check("R2 spawn", int'(spawn_o), 1);
        tick();
        quiet();
        #1;
    endtask

    // Check the state right after reset.
    task automatic t_reset();
        check("R1 valid", int'(hlp_valid_o), 0);
        check("R1 spawn", int'(spawn_o), 0);
        check("R1 kill", int'(kill_o), 0);
    endtask

    // Lead selection, confidence gating, lowest free core, slot fill.
    task automatic t_spawn_basic();
        core_busy = 4'b0011; ranks(3, 3, 0, 0);
        miss_pred = 4'b0010; conf_ok = 4'b0010; #1;
        check("R2 tie non-lead ignored", int'(spawn_o), 0);
        miss_pred = 4'b0001; conf_ok = 4'b0000; #1;
        check("R2 no confidence", int'(spawn_o), 0);
        conf_ok = 4'b0001; #1;
        check("R2 lead spawn", int'(spawn_o), 1);
        check("R2 parent", int'(spawn_parent_o), 0);
        check("R4 lowest free", int'(spawn_core_o), 2);
        tick();
        check("R5 valid", int'(hlp_valid_o), 1);
        check("R5 parent", int'(hlp_parent_o), 0);
        check("R5 core", int'(hlp_core_o), 2);
        check("R12 no second spawn", int'(spawn_o), 0);
        quiet(); #1;
    endtask

    // Higher rank appears: kill in the same cycle, then slot empties, core reused.
    task automatic t_lead_lost();
        core_busy = 4'b1011; ranks(3, 3, 0, 9); #1;
        check("R6 kill on lead loss", int'(kill_o), 1);
        check("R9 kill core", int'(kill_core_o), 2);
        check("R9 discard", int'(discard_o), 4);
        tick();
        check("R10 slot empty", int'(hlp_valid_o), 0);
        check("R9 single pulse", int'(kill_o), 0);
        miss_pred = 4'b1000; conf_ok = 4'b1000; #1;
        check("R10 core reused", int'(spawn_core_o), 2);
        check("R2 new parent", int'(spawn_parent_o), 3);
        check("R10 spawn again", int'(spawn_o), 1);
        tick(); quiet(); #1;
    endtask

    // Squash filtering with and without a helper.
    task automatic t_squash();
        sq_in = 4'b1111; sq_raise = 4'b1111; #1;
        check("R11 deliver", int'(sq_deliver_o), 4'b1011);
        check("R11 emit", int'(sq_emit_o), 4'b1011);
        quiet(); #1;
    endtask

    // Parent finishing, helper finishing, exception, and combined causes.
    task automatic t_done_exc();
        core_done = 4'b1000; #1;
        check("R7 parent done", int'(kill_o), 1);
        tick(); quiet(); #1;
        do_spawn(3);
        core_done = 4'b0100; #1;
        check("R7 helper done", int'(kill_o), 1);
        tick(); quiet(); #1;
        sq_in = 4'b1111; #1;
        check("R11 pass with no helper", int'(sq_deliver_o), 15);
        quiet();
        do_spawn(3);
        core_exc = 4'b0100; #1;
        check("R8 helper exception", int'(kill_o), 1);
        tick(); quiet(); #1;
        do_spawn(3);
        core_exc = 4'b0100; core_done = 4'b1000; #1;
        check("R9 combined kill", int'(kill_o), 1);
        check("R9 combined discard", int'(discard_o), 4);
        tick(); quiet(); #1;
        check("R9 combined one pulse", int'(kill_o), 0);
        check("R10 cleared after combined", int'(hlp_valid_o), 0);
    endtask

    // No free core: request dropped and not remembered.
    task automatic t_full();
        core_busy = 4'b1111; ranks(0, 1, 2, 3);
        miss_pred = 4'b1000; conf_ok = 4'b1000; #1;
        check("R3 no free core", int'(spawn_o), 0);
        tick();
        quiet(); core_busy = 4'b1110; #1;
        check("R3 dropped request", int'(spawn_o), 0);
        tick();
        check("R3 nothing stored", int'(hlp_valid_o), 0);
        miss_pred = 4'b1000; conf_ok = 4'b1000; #1;
        check("R4 freed core zero", int'(spawn_core_o), 0);
        check("R3 spawn after free", int'(spawn_o), 1);
        tick(); quiet();
        core_busy = 4'b0110; #1;
        check("R6 parent not busy", int'(kill_o), 1);
        tick();
    endtask

    // Stop a hung run, counting it as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; core_busy = '0; ranks(0, 0, 0, 0); quiet();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_spawn_basic();
        t_lead_lost();
        t_squash();
        t_done_exc();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule